// File: doc/BRIEF.md
# Shared LED/GPIO Pin Controller

This block holds one 32-bit configuration word and the per-pin logic behind it for a small group of pins that may each act either as an LED driver or as a general-purpose I/O, plus a pair of dedicated general-purpose outputs. For every shared pin, software picks the function (LED or GPIO), the direction, and the output drive style (push-pull, or open-drain that only pulls low). An LED pin is always driven push-pull from an LED source signal made elsewhere in the chip. In that case its direction and drive settings are ignored.

Each GPIO input is brought into the clock domain by a synchronizer chain. It then passes through a level qualifier. The qualifier accepts the active level only once that level has been present for a minimum number of clock cycles. The active level is chosen per pin by a polarity bit. A qualified level sets a sticky status bit, which software clears by writing a one. A second register holds per-pin enables. The interrupt output is the OR of the status bits that are enabled. A 3-bit field for an external memory pin function is kept as storage only.

The register bus is word addressed. Address 0 is the configuration word, address 1 is the status register (write one to clear), and address 2 is the enable register. Writes take effect at the clock edge. Reads are combinational.

Top module: `gpio_led_ctrl`

## Requirements
- R1: After reset, every register reads zero (except the live input bits 2:0 of the configuration word), every pad output enable is 0, the dedicated outputs are 0 and the interrupt output is 0.
- R2: In the configuration word only bits 30:28, 26:24, 22:20, 18:16, 10:8, 4:3 and 2:0 are writable. Writing all ones reads back 0x7777071F.
- R3: When the function bit of pin i (bit 28+i) is 1, pad_oe[i] is 1 and pad_out[i] follows led_src[i], whatever the direction and drive bits are.
- R4: When pin i is a GPIO and its direction bit (bit 8+i) is 0, pad_oe[i] is 0.
- R5: For a GPIO output pin i with data bit i (bit i): if drive bit 16+i is 1 (push-pull), pad_oe[i]=1 and pad_out[i]=data; if it is 0 (open-drain), pad_out[i]=0 and pad_oe[i]=NOT data.
- R6: Configuration bits 4:3 appear directly on gpo_out[1:0].
- R7: Reading configuration bit i (2:0) returns the stored data bit when pin i is a GPIO output. Otherwise it returns the synchronized level of pad_in[i].
- R8: Status bit i (address 1) sets when the synchronized pad_in[i] equals polarity bit 24+i for at least QUAL_CYC consecutive cycles. Activity that lasts fewer cycles sets nothing.
- R9: Status bits stay set until a 1 is written to them at address 1. If the qualified level is still present, the bit stays set in that same cycle.
- R10: irq is 1 exactly when some status bit i is set and enable bit i (address 2, bits 2:0) is set.
- R11: Bits 22:20 read back as written and have no effect on any pin.
- R12: A status bit does not set while its pin is in LED function.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word address: 0 config, 1 status, 2 enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | N_PIN | Pin levels from the pads |
| pad_out | output | N_PIN | Value driven to the pads |
| pad_oe | output | N_PIN | Output enable per pad |
| led_src | input | N_PIN | LED source signals |
| gpo_out | output | N_GPO | Dedicated general-purpose outputs |
| irq | output | 1 | Interrupt request |

## Verification
A write-one-to-clear of a status bit and the set from a qualified level can reach the status register in the same cycle. To force this, the bench holds a pin at its active level, waits until the status bit is set, and then clears it by writing a one. The set must win, so the read that follows must still show the bit at 1. The same clear with the level released must show 0. A second overlap is a new qualification that lands while the pin is being switched into LED function. A read taken after the qualification window must show the status bit still clear.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
   localparam int unsigned REG_W   = 32;
   localparam int unsigned LED_LSB = 28;
   localparam int unsigned POL_LSB = 24;
   localparam int unsigned EEP_LSB = 20;
   localparam int unsigned BUF_LSB = 16;
   localparam int unsigned DIR_LSB = 8;
   localparam int unsigned GPO_LSB = 3;
   localparam int unsigned DAT_LSB = 0;
   localparam int unsigned EEP_W   = 3;
   localparam int unsigned FLD_MAX = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_level_qual.sv
module gpio_level_qual #(
   parameter int unsigned QUAL_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic qual
);
   if (QUAL_CYC == 0) begin : g_bypass
      assign qual = active;
   end else begin : g_count
      localparam int unsigned CW = $clog2(QUAL_CYC + 1);
      localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYC);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cnt_q <= '0;
         else if (!active)        cnt_q <= '0;
         else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      end

      assign qual = (cnt_q == LIMIT);

      AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= LIMIT); // R8
      AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         !active |=> (cnt_q == '0)); // R8
   end
endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv (
   input  logic led_en,
   input  logic dir_out,
   input  logic push_pull,
   input  logic data,
   input  logic led_src,
   output logic oe,
   output logic out
);
   always_comb begin
      oe  = 1'b0;
      out = 1'b0;
      if (led_en) begin
         oe  = 1'b1;
         out = led_src;
      end else if (dir_out) begin
         if (push_pull) begin
            oe  = 1'b1;
            out = data;
         end else begin
            oe  = ~data;
            out = 1'b0;
         end
      end
   end
endmodule

// File: rtl/gpio_led_ctrl.sv
module gpio_led_ctrl
   import gpio_ctrl_pkg::*;
#(
   parameter int unsigned N_PIN       = 3,
   parameter int unsigned N_GPO       = 2,
   parameter int unsigned QUAL_CYC    = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [N_PIN-1:0]  pad_in,
   output logic [N_PIN-1:0]  pad_out,
   output logic [N_PIN-1:0]  pad_oe,
   input  logic [N_PIN-1:0]  led_src,
   output logic [N_GPO-1:0]  gpo_out,
   output logic              irq
);
   localparam logic [31:0] PIN_M = 32'((1 << N_PIN) - 1);
   localparam logic [31:0] GPO_M = 32'((1 << N_GPO) - 1);
   localparam logic [31:0] EEP_M = 32'((1 << EEP_W) - 1);
   localparam logic [31:0] CFG_WMASK = (PIN_M << LED_LSB) | (PIN_M << POL_LSB)
                                     | (EEP_M << EEP_LSB) | (PIN_M << BUF_LSB)
                                     | (PIN_M << DIR_LSB) | (GPO_M << GPO_LSB)
                                     | (PIN_M << DAT_LSB);
   localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(2);

   if (N_PIN < 1 || N_PIN > FLD_MAX) begin : g_bad_pin
      $error("gpio_led_ctrl: N_PIN must be 1..3");
   end
   if (N_GPO < 1 || N_GPO > 2) begin : g_bad_gpo
      $error("gpio_led_ctrl: N_GPO must be 1..2");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("gpio_led_ctrl: ADDR_W must be at least 2");
   end

   logic [31:0]      cfg_q;
   logic [N_PIN-1:0] sts_q, en_q;
   logic [N_PIN-1:0] led_en, pol, pp, dir_o, dat;
   logic [N_PIN-1:0] pin_sync, qual, sts_set, w1c, rbk;
   logic [31:0]      rd_cfg;

   assign led_en  = cfg_q[LED_LSB +: N_PIN];
   assign pol     = cfg_q[POL_LSB +: N_PIN];
   assign pp      = cfg_q[BUF_LSB +: N_PIN];
   assign dir_o   = cfg_q[DIR_LSB +: N_PIN];
   assign dat     = cfg_q[DAT_LSB +: N_PIN];
   assign gpo_out = cfg_q[GPO_LSB +: N_GPO];

   assign w1c = (bus_wr && bus_addr == A_STS) ? bus_wdata[N_PIN-1:0] : '0;

   for (genvar i = 0; i < N_PIN; i++) begin : g_pin
      logic active;

      gpio_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst_n(rst_n), .din(pad_in[i]), .dout(pin_sync[i]));

      assign active = (pin_sync[i] == pol[i]);

      gpio_level_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
         .clk(clk), .rst_n(rst_n), .active(active), .qual(qual[i]));

      gpio_pin_drv u_drv (
         .led_en(led_en[i]), .dir_out(dir_o[i]), .push_pull(pp[i]),
         .data(dat[i]), .led_src(led_src[i]), .oe(pad_oe[i]), .out(pad_out[i]));

      assign sts_set[i] = qual[i] & ~led_en[i];
      assign rbk[i]     = (dir_o[i] & ~led_en[i]) ? dat[i] : pin_sync[i];

      AST_LED_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
         led_en[i] |-> (pad_oe[i] && pad_out[i] == led_src[i])); // R3
      AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
         (!led_en[i] && !dir_o[i]) |-> !pad_oe[i]); // R4
      AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
         (!led_en[i] && dir_o[i] && !pp[i]) |-> !pad_out[i]); // R5
      AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (sts_q[i] && !w1c[i]) |=> sts_q[i]); // R9
      AST_STS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(sts_q[i]) |-> $past(qual[i])); // R8
      AST_LED_NO_STS: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(sts_q[i]) |-> !$past(led_en[i])); // R12
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         sts_q <= '0;
         en_q  <= '0;
      end else begin
         if (bus_wr && bus_addr == A_CFG) cfg_q <= bus_wdata & CFG_WMASK;
         if (bus_wr && bus_addr == A_EN)  en_q  <= bus_wdata[N_PIN-1:0];
         sts_q <= (sts_q & ~w1c) | sts_set;
      end
   end

   assign irq = |(sts_q & en_q);

   always_comb begin
      rd_cfg = cfg_q;
      rd_cfg[DAT_LSB +: N_PIN] = rbk;
   end

   always_comb begin
      case (bus_addr)
         A_CFG:   bus_rdata = rd_cfg;
         A_STS:   bus_rdata = 32'(sts_q);
         A_EN:    bus_rdata = 32'(en_q);
         default: bus_rdata = '0;
      endcase
   end

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (en_q != '0 && sts_q != '0)); // R10
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q & ~CFG_WMASK) == '0); // R2
endmodule

// File: tb/gpio_led_ctrl_test.sv
module gpio_led_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [2:0]  pad_in = 3'b111;
   logic [2:0]  pad_out, pad_oe;
   logic [2:0]  led_src = '0;
   logic [1:0]  gpo_out;
   logic        irq;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gpio_led_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .led_src(led_src),
      .gpo_out(gpo_out), .irq(irq));

   // cfg, led_src, expected oe, expected out, expected gpo
   localparam int NV = 6;
   localparam logic [31:0] V_CFG [NV] = '{32'h0000_0000, 32'h0007_0705, 32'h0000_0705,
                                          32'h7000_0000, 32'h4001_0303, 32'h0050_0010};
   localparam logic [2:0]  V_LED [NV] = '{3'b000, 3'b000, 3'b000, 3'b110, 3'b100, 3'b000};
   localparam logic [2:0]  V_OE  [NV] = '{3'b000, 3'b111, 3'b010, 3'b111, 3'b101, 3'b000};
   localparam logic [2:0]  V_OUT [NV] = '{3'b000, 3'b101, 3'b000, 3'b110, 3'b101, 3'b000};
   localparam logic [1:0]  V_GPO [NV] = '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b10};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd(2'd0, r); check("R1 cfg", r, 32'h0000_0000);
      rd(2'd1, r); check("R1 sts", r, 32'h0);
      rd(2'd2, r); check("R1 en", r, 32'h0);
      check("R1 oe", 32'(pad_oe), 32'h0);
      check("R1 gpo/irq", {29'h0, gpo_out, irq}, 32'h0);
      idle(4);
      rd(2'd0, r); check("R7 input readback after reset", r, 32'h0000_0007);

      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, r); check("R2 reserved bits", r & 32'hFFFF_FFF8, 32'h7777_0718);

      for (int k = 0; k < NV; k++) begin
         led_src = V_LED[k];
         wr(2'd0, V_CFG[k]);
         #1;
         check("R3/R4/R5 oe", 32'(pad_oe), 32'(V_OE[k]));
         check("R3/R4/R5 out", 32'(pad_out), 32'(V_OUT[k]));
         check("R6 gpo", 32'(gpo_out), 32'(V_GPO[k]));
      end
      rd(2'd0, r); check("R11 eeprom field stored", r & 32'hFFFF_FFF8, 32'h0050_0010);

      // R7: output readback and input readback
      wr(2'd0, 32'h0007_0702);
      rd(2'd0, r); check("R7 output readback", r & 32'h7, 32'h2);
      wr(2'd0, 32'h0);
      pad_in = 3'b101;
      idle(4);
      rd(2'd0, r); check("R7 input readback", r & 32'h7, 32'h5);
      pad_in = 3'b111;
      idle(4);

      wr(2'd1, 32'h7);
      rd(2'd1, r); check("R8 idle status clear", r, 32'h0);
      // R8 short pulse ignored
      @(negedge clk); pad_in[0] = 1'b0;
      @(negedge clk); pad_in[0] = 1'b1;
      idle(6);
      rd(2'd1, r); check("R8 short pulse ignored", r, 32'h0);
      // R8 pulse of QUAL_CYC cycles accepted
      @(negedge clk); pad_in[0] = 1'b0;
      idle(2); pad_in[0] = 1'b1;
      idle(6);
      rd(2'd1, r); check("R8 qualified pulse", r, 32'h1);
      check("R10 irq masked", 32'(irq), 32'h0);
      wr(2'd2, 32'h1);
      check("R10 irq enabled", 32'(irq), 32'h1);
      wr(2'd2, 32'h0);
      check("R10 irq disabled", 32'(irq), 32'h0);
      // R9 clear with level gone
      wr(2'd1, 32'h1);
      rd(2'd1, r); check("R9 w1c clears", r, 32'h0);
      // R9 clear while level held: set wins
      pad_in[0] = 1'b0;
      idle(6);
      wr(2'd1, 32'h1);
      rd(2'd1, r); check("R9 set wins over clear", r, 32'h1);
      pad_in[0] = 1'b1;
      idle(6);
      wr(2'd1, 32'h1);
      rd(2'd1, r); check("R9 cleared after release", r, 32'h0);
      // R8 high polarity on pin 1
      wr(2'd0, 32'h0200_0000);
      idle(6);
      rd(2'd1, r); check("R8 high polarity", r, 32'h2);
      // R12 LED function blocks status
      wr(2'd0, 32'h2200_0000);
      wr(2'd1, 32'h2);
      idle(6);
      rd(2'd1, r); check("R12 LED pin no status", r, 32'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual running expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule